// File: doc/BRIEF.md
# Banked Packet-Controller Register Window

This block is the host-facing register window of a packet-buffer network controller. The host sees sixteen byte locations. Offset 14 holds a two-bit bank number, and that number decides which of four register sets the offsets 0 to 13 reach. Offset 15 is a fixed identification byte. Bank 2 contains a 16-bit address pointer and a four-byte data port. The data port reads and writes bytes of a 2048-byte packet page, and that page sits in a packet memory outside this block.

The host bus is synchronous and 32 bits wide. `host_waddr` selects one of four words, and each set bit of `host_be` makes one byte access at offset `4*host_waddr + lane`. The bytes are handled in order of increasing lane. All bytes of one access decode against the bank that was selected when the access started. Read data comes back on the cycle after the request, lanes assembled little-endian. The packet memory receives one byte port per lane and returns its read data one cycle after the enable. The page allocator is a separate block. It receives the command and interrupt-acknowledge pulses from this block and supplies the allocation result, the receive-queue head and the transmit-done head.

The pointer carries three fields. Bits 10:0 are the byte offset within the page. Bit 14 selects auto-increment. Bit 15 selects the receive-queue head as the page instead of the packet-number register.

Top module: `pktbuf_reg_window`

## Requirements
- R1: After reset the bank is 0, the pointer is 0, both transmit and receive control words are 0x0000, the configuration word reads 0xA0B1, the control word reads 0x1210, and bank 3 offset 12 reads 0x1F.
- R2: A write to offset 14 stores bits 1:0 of the byte as the bank, and the bank reads back at offset 14 in every bank. Offset 15 reads 0x33 in every bank, and writes to it change nothing.
- R3: The same offset reaches different registers in different banks: offsets 0/1 are the transmit control word in bank 0 and the configuration word in bank 1.
- R4: A data-port access uses the page given by the low bits of `rx_head` when pointer bit 15 is 1, and the page given by the packet-number register (bank 2 offset 2) when pointer bit 15 is 0.
- R5: When pointer bit 14 is 1, the k-th enabled data byte of an access uses page offset pointer[10:0]+k, and pointer[10:0] then advances by the number of data bytes. The count wraps from 2047 to 0, and pointer bits 15:11 do not change.
- R6: When pointer bit 14 is 0, a data byte at window offset 8+j (j = 0 to 3) uses page offset pointer[10:0]+j, and the pointer does not change.
- R7: A read returns byte lane l of `host_rdata` from offset 4*host_waddr+l on the cycle after the request. Lanes that are not enabled return 0.
- R8: A write with all four byte enables to word 3 writes only offsets 14 and 15, so offsets 12 and 13 keep their values.
- R9: Reading the pointer high byte (bank 2 offset 7) returns it ANDed with 0xF7.
- R10: Writing the receive-control high byte (bank 0 offset 5) with bit 7 set returns every register to its R1 value, including the receive control word itself. `soft_rst_o` pulses for one cycle after that write.
- R11: Bits 1:0 of a write to the control low byte (bank 1 offset 12) are never stored and always read 0.
- R12: Writes to bank 0 offsets 2,3,6,7,8,9 and to bank 3 offsets 10,11 change no register and raise `host_err` for one cycle after the write. No other access raises it.
- R13: A write to bank 2 offset 0 pulses `cmd_valid` with `cmd_code` = byte bits 7:5. A write to bank 2 offset 12 pulses `ack_valid` with the byte. Bank 2 offset 13 stores the interrupt mask, and offset 12 reads `irq_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_waddr | input | 2 | Word index within the 16-byte window |
| host_be | input | 4 | Byte enables, one per lane |
| host_wr | input | 1 | Write request, one cycle |
| host_rd | input | 1 | Read request, one cycle |
| host_wdata | input | 32 | Write data, lane l in bits 8l+7:8l |
| host_rdata | output | 32 | Read data, valid the cycle after `host_rd` |
| host_err | output | 1 | Illegal write seen on the previous cycle |
| mem_page | output | PAGE_W | Packet page for the data port |
| mem_en | output | 4 | Per-lane packet memory enable |
| mem_we | output | 4 | Per-lane packet memory write |
| mem_off | output | 4*11 | Per-lane page byte offset |
| mem_wdata | output | 32 | Per-lane write bytes |
| mem_rdata | input | 32 | Per-lane read bytes, one cycle after enable |
| alloc_result | input | 8 | Allocation result from the allocator |
| txdone_head | input | 8 | Head of the transmit-done queue |
| rx_head | input | 8 | Head of the receive queue |
| irq_status | input | 8 | Interrupt status byte |
| cmd_valid | output | 1 | Allocator command pulse |
| cmd_code | output | 3 | Allocator command code |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_bits | output | 8 | Interrupt acknowledge byte |
| soft_rst_o | output | 1 | Software reset pulse |
| tx_ctrl | output | 16 | Transmit control word |
| rx_ctrl | output | 16 | Receive control word |
| irq_mask | output | 8 | Interrupt mask |

## Verification
The hardest case to reach is a pointer auto-increment that wraps from 2047 to 0 inside one 32-bit access while the upper pointer bits are set. Those upper bits include bit 11, which the masked high-byte read hides. To get there, the stimulus writes the pointer bytes one at a time to put it two bytes below the page end, then makes a full-word data access. The bench then checks the four bytes in its memory model at offsets 0x7FE, 0x7FF, 0x000 and 0x001. It also reads the pointer back and checks the low byte, and checks the high byte with bit 11 masked. A second full-word access from the same starting point reads the bytes back across the wrap, and a sparse byte-enable access confirms that the offsets are numbered by data-byte order.

// File: rtl/pktbuf_reg_window.sv
module pktbuf_reg_window #(
  parameter int          PAGE_W  = 2,
  parameter logic [7:0]  REV     = 8'h91,
  parameter logic [15:0] CFG_RST = 16'hA0B1,
  parameter logic [15:0] CTL_RST = 16'h1210,
  parameter logic [4:0]  ERX_RST = 5'h1F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_waddr,
  input  logic [3:0]          host_be,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                host_err,
  output logic [PAGE_W-1:0]   mem_page,
  output logic [3:0]          mem_en,
  output logic [3:0]          mem_we,
  output logic [4*11-1:0]     mem_off,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic [7:0]          alloc_result,
  input  logic [7:0]          txdone_head,
  input  logic [7:0]          rx_head,
  input  logic [7:0]          irq_status,
  output logic                cmd_valid,
  output logic [2:0]          cmd_code,
  output logic                ack_valid,
  output logic [7:0]          ack_bits,
  output logic                soft_rst_o,
  output logic [15:0]         tx_ctrl,
  output logic [15:0]         rx_ctrl,
  output logic [7:0]          irq_mask
);
  localparam int OFF_W     = 11;
  localparam int LANES     = 4;
  localparam int NUM_PAGES = 1 << PAGE_W;

  logic [1:0]  bank_q;
  logic [15:0] txc_q, rxc_q, cfg_q, gp_q, ctl_q, ptr_q;
  logic [7:0]  pnum_q, imask_q;
  logic [4:0]  erx_q;
  logic [31:0] rdata_q;
  logic [3:0]  dsel_q;
  logic        err_q, srst_q, cmdv_q, ackv_q;
  logic [2:0]  cmd_q;
  logic [7:0]  ack_q;

  logic             acc, narrow, srst_hit, err_hit;
  logic [3:0]       lane_act, lane_dat;
  logic [3:0]       boff  [LANES];
  logic [7:0]       wbyte [LANES];
  logic [OFF_W-1:0] loff  [LANES];
  logic [2:0]       ndat;

  assign acc    = host_wr | host_rd;
  assign narrow = host_wr && host_waddr == 2'd3 && host_be == 4'hF;

  always_comb begin
    ndat = '0;
    for (int l = 0; l < LANES; l++) begin
      boff[l]     = {host_waddr, 2'(l)};
      wbyte[l]    = host_wdata[8*l +: 8];
      lane_act[l] = acc && host_be[l] && !(narrow && l < 2);
      lane_dat[l] = lane_act[l] && bank_q == 2'd2 && host_waddr == 2'd2;
      loff[l]     = ptr_q[14] ? ptr_q[OFF_W-1:0] + OFF_W'(ndat)
                              : ptr_q[OFF_W-1:0] + OFF_W'(l);
      if (lane_dat[l]) ndat = ndat + 3'd1;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) mem_off[OFF_W*l +: OFF_W] = loff[l];
  end

  assign mem_page  = ptr_q[15] ? rx_head[PAGE_W-1:0] : pnum_q[PAGE_W-1:0];
  assign mem_en    = lane_dat;
  assign mem_we    = lane_dat & {LANES{host_wr}};
  assign mem_wdata = host_wdata;

  function automatic logic bad_wr(input logic [3:0] off);
    if (off == 4'd14 || off == 4'd15) return 1'b0;
    if (bank_q == 2'd0) return off inside {4'd2, 4'd3, 4'd6, 4'd7, 4'd8, 4'd9};
    if (bank_q == 2'd3) return off inside {4'd10, 4'd11};
    return 1'b0;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [3:0] off);
    logic [7:0] r;
    r = 8'h00;
    if (off == 4'd14) r = {6'b0, bank_q};
    else if (off == 4'd15) r = 8'h33;
    else begin
      case (bank_q)
        2'd0: case (off)
          4'd0: r = txc_q[7:0];
          4'd1: r = txc_q[15:8];
          4'd3: r = 8'h40;
          4'd4: r = rxc_q[7:0];
          4'd5: r = rxc_q[15:8];
          4'd8: r = 8'(NUM_PAGES);
          default: r = 8'h00;
        endcase
        2'd1: case (off)
          4'd0:  r = cfg_q[7:0];
          4'd1:  r = cfg_q[15:8];
          4'd10: r = gp_q[7:0];
          4'd11: r = gp_q[15:8];
          4'd12: r = ctl_q[7:0];
          4'd13: r = ctl_q[15:8];
          default: r = 8'h00;
        endcase
        2'd2: case (off)
          4'd2:  r = pnum_q;
          4'd3:  r = alloc_result;
          4'd4:  r = txdone_head;
          4'd5:  r = rx_head;
          4'd6:  r = ptr_q[7:0];
          4'd7:  r = ptr_q[15:8] & 8'hF7;
          4'd12: r = irq_status;
          4'd13: r = imask_q;
          default: r = 8'h00;
        endcase
        default: case (off)
          4'd8:  r = 8'h30;
          4'd9:  r = 8'h33;
          4'd10: r = REV;
          4'd11: r = 8'h33;
          4'd12: r = {3'b0, erx_q};
          default: r = 8'h00;
        endcase
      endcase
    end
    return r;
  endfunction

  always_comb begin
    srst_hit = 1'b0;
    err_hit  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (host_wr && lane_act[l]) begin
        if (bank_q == 2'd0 && boff[l] == 4'd5 && wbyte[l][7]) srst_hit = 1'b1;
        if (bad_wr(boff[l])) err_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0; txc_q <= '0; rxc_q <= '0; cfg_q <= CFG_RST; gp_q <= '0;
      ctl_q <= CTL_RST; pnum_q <= '0; ptr_q <= '0; imask_q <= '0; erx_q <= ERX_RST;
      rdata_q <= '0; dsel_q <= '0; err_q <= 1'b0; srst_q <= 1'b0;
      cmdv_q <= 1'b0; cmd_q <= '0; ackv_q <= 1'b0; ack_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        rdata_q[8*l +: 8] <= (host_rd && lane_act[l] && !lane_dat[l]) ? rd_byte(boff[l]) : 8'h00;
      dsel_q <= host_rd ? lane_dat : 4'b0;
      err_q  <= err_hit;
      srst_q <= srst_hit;
      cmdv_q <= 1'b0;
      ackv_q <= 1'b0;
      if (srst_hit) begin
        bank_q <= '0; txc_q <= '0; rxc_q <= '0; cfg_q <= CFG_RST; gp_q <= '0;
        ctl_q <= CTL_RST; pnum_q <= '0; ptr_q <= '0; imask_q <= '0; erx_q <= ERX_RST;
      end else begin
        if (ptr_q[14] && |lane_dat)
          ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + OFF_W'(ndat);
        for (int l = 0; l < LANES; l++) begin
          if (host_wr && lane_act[l]) begin
            if (boff[l] == 4'd14) bank_q <= wbyte[l][1:0];
            else if (boff[l] != 4'd15) begin
              case (bank_q)
                2'd0: case (boff[l])
                  4'd0: txc_q[7:0]  <= wbyte[l];
                  4'd1: txc_q[15:8] <= wbyte[l];
                  4'd4: rxc_q[7:0]  <= wbyte[l];
                  4'd5: rxc_q[15:8] <= wbyte[l];
                  default: ;
                endcase
                2'd1: case (boff[l])
                  4'd0:  cfg_q[7:0]  <= wbyte[l];
                  4'd1:  cfg_q[15:8] <= wbyte[l];
                  4'd10: gp_q[7:0]   <= wbyte[l];
                  4'd11: gp_q[15:8]  <= wbyte[l];
                  4'd12: ctl_q[7:0]  <= wbyte[l] & 8'hFC;
                  4'd13: ctl_q[15:8] <= wbyte[l];
                  default: ;
                endcase
                2'd2: case (boff[l])
                  4'd0:  begin cmdv_q <= 1'b1; cmd_q <= wbyte[l][7:5]; end
                  4'd2:  pnum_q <= wbyte[l];
                  4'd6:  ptr_q[7:0]  <= wbyte[l];
                  4'd7:  ptr_q[15:8] <= wbyte[l];
                  4'd12: begin ackv_q <= 1'b1; ack_q <= wbyte[l]; end
                  4'd13: imask_q <= wbyte[l];
                  default: ;
                endcase
                default: case (boff[l])
                  4'd12: erx_q <= wbyte[l][4:0];
                  default: ;
                endcase
              endcase
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      host_rdata[8*l +: 8] = dsel_q[l] ? mem_rdata[8*l +: 8] : rdata_q[8*l +: 8];
  end

  assign host_err   = err_q;
  assign soft_rst_o = srst_q;
  assign cmd_valid  = cmdv_q;
  assign cmd_code   = cmd_q;
  assign ack_valid  = ackv_q;
  assign ack_bits   = ack_q;
  assign tx_ctrl    = txc_q;
  assign rx_ctrl    = rxc_q;
  assign irq_mask   = imask_q;

  a_r5_upper_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_dat && ptr_q[14]) |=> ptr_q[15:11] == $past(ptr_q[15:11]));

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_dat && !ptr_q[14]) |=> $stable(ptr_q));

  a_r10_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (rx_ctrl == 16'h0 && bank_q == 2'd0 && ptr_q == 16'h0));

  a_r11_cmd_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1:0] == 2'b00);

  a_r12_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> $past(host_wr));

  a_r13_cmd_from_bank2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(host_wr) && $past(bank_q) == 2'd2));
endmodule

// File: tb/pktbuf_reg_window_tb.sv
module pktbuf_reg_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] host_waddr = '0;
  logic [3:0] host_be = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_err;
  logic [PW-1:0] mem_page;
  logic [3:0] mem_en, mem_we;
  logic [43:0] mem_off;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [7:0] alloc_result = 8'h80, txdone_head = 8'h80, rx_head = 8'h03, irq_status = 8'h81;
  logic cmd_valid, ack_valid, soft_rst_o;
  logic [2:0] cmd_code;
  logic [7:0] ack_bits, irq_mask;
  logic [15:0] tx_ctrl, rx_ctrl;

  int ntests = 0, nfail = 0;
  logic l_err, l_cmdv, l_ackv, l_srst;
  logic [2:0] l_cmd;
  logic [7:0] l_ack;
  byte unsigned mem [int];

  pktbuf_reg_window #(.PAGE_W(PW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (mem_en[l]) begin
        int idx;
        idx = int'(mem_page) * 2048 + int'(mem_off[11*l +: 11]);
        mem_rdata[8*l +: 8] <= mem.exists(idx) ? mem[idx] : 8'h00;
        if (mem_we[l]) mem[idx] = mem_wdata[8*l +: 8];
      end
    end
  end

  function automatic logic [7:0] mget(int page, int off);
    int idx = page * 2048 + off;
    return mem.exists(idx) ? mem[idx] : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    host_waddr = a; host_be = be; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_be = '0;
    l_err = host_err; l_cmdv = cmd_valid; l_cmd = cmd_code;
    l_ackv = ack_valid; l_ack = ack_bits; l_srst = soft_rst_o;
  endtask

  task automatic rd(logic [1:0] a, logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    host_waddr = a; host_be = be; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_be = '0;
    d = host_rdata;
    l_err = host_err;
  endtask

  task automatic wb(logic [3:0] off, logic [7:0] v);
    wr(off[3:2], 4'b1 << off[1:0], {24'b0, v} << (8 * off[1:0]));
  endtask

  task automatic rb(logic [3:0] off, output logic [7:0] v);
    logic [31:0] d;
    rd(off[3:2], 4'b1 << off[1:0], d);
    v = d[8*off[1:0] +: 8];
  endtask

  task automatic set_bank(logic [1:0] b);
    wb(4'd14, {6'b0, b});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rb(4'd14, v); chk("R1 bank", v, 8'h00);
    rb(4'd15, v); chk("R2 id byte", v, 8'h33);
    chk("R1 tx ctrl", tx_ctrl, 16'h0);
    chk("R1 rx ctrl", rx_ctrl, 16'h0);
    set_bank(2'd1);
    rb(4'd0, v); chk("R1 cfg lo", v, 8'hB1);
    rb(4'd1, v); chk("R1 cfg hi", v, 8'hA0);
    rb(4'd12, v); chk("R1 ctl lo", v, 8'h10);
    rb(4'd13, v); chk("R1 ctl hi", v, 8'h12);
    set_bank(2'd2);
    rb(4'd6, v); chk("R1 ptr lo", v, 8'h00);
    set_bank(2'd3);
    rb(4'd12, v); chk("R1 early rx", v, 8'h1F);
  endtask

  task automatic t_bank;
    logic [7:0] v;
    set_bank(2'd3);
    rb(4'd14, v); chk("R2 bank readback", v, 8'h03);
    wb(4'd15, 8'h00);
    rb(4'd15, v); chk("R2 offset15 write ignored", v, 8'h33);
    rb(4'd14, v); chk("R2 bank after off15 write", v, 8'h03);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    set_bank(2'd0); wb(4'd0, 8'h34); wb(4'd1, 8'h12);
    set_bank(2'd1); wb(4'd0, 8'h78); wb(4'd1, 8'h56);
    rd(2'd0, 4'b0011, d); chk("R3 bank1 cfg word", d, 32'h5678);
    set_bank(2'd0);
    rd(2'd0, 4'b0011, d); chk("R3 bank0 tx word", d, 32'h1234);
    chk("R3 tx_ctrl port", tx_ctrl, 16'h1234);
  endtask

  task automatic t_ctrl_mask;
    logic [7:0] v;
    set_bank(2'd1); wb(4'd12, 8'hFF);
    rb(4'd12, v); chk("R11 ctl low cmd bits", v, 8'hFC);
  endtask

  task automatic t_narrow;
    logic [7:0] v;
    set_bank(2'd1);
    wr(2'd3, 4'hF, 32'hAA02_55CC);
    rb(4'd14, v); chk("R8 bank from wide write", v, 8'h02);
    set_bank(2'd1);
    rb(4'd12, v); chk("R8 off12 untouched", v, 8'hFC);
    rb(4'd13, v); chk("R8 off13 untouched", v, 8'h12);
  endtask

  task automatic t_fixed_ptr;
    logic [31:0] d;
    logic [7:0] v;
    set_bank(2'd2);
    wb(4'd2, 8'h01); wb(4'd6, 8'h10); wb(4'd7, 8'h00);
    wr(2'd2, 4'hF, 32'h4433_2211);
    chk("R6 byte at +0", mget(1, 16'h10), 8'h11);
    chk("R6 byte at +3", mget(1, 16'h13), 8'h44);
    rd(2'd2, 4'b0100, d); chk("R6 lane2 read +2", d, 32'h0033_0000);
    rd(2'd2, 4'hF, d);   chk("R7 wide data read", d, 32'h4433_2211);
    rb(4'd6, v); chk("R6 ptr lo unchanged", v, 8'h10);
    wb(4'd6, 8'h20); wb(4'd7, 8'h80);
    wr(2'd2, 4'b0001, 32'h77);
    chk("R4 rx head page", mget(3, 16'h20), 8'h77);
    chk("R4 tx page untouched", mget(1, 16'h20), 8'h00);
  endtask

  task automatic t_autoinc;
    logic [31:0] d;
    logic [7:0] v;
    set_bank(2'd2);
    wb(4'd2, 8'h02); wb(4'd6, 8'hFE); wb(4'd7, 8'h4F);
    wr(2'd2, 4'hF, 32'h0403_0201);
    chk("R5 off 0x7FE", mget(2, 16'h7FE), 8'h01);
    chk("R5 off 0x7FF", mget(2, 16'h7FF), 8'h02);
    chk("R5 wrap off 0", mget(2, 0), 8'h03);
    chk("R5 wrap off 1", mget(2, 1), 8'h04);
    rb(4'd6, v); chk("R5 ptr lo advanced", v, 8'h02);
    rb(4'd7, v); chk("R9 ptr hi masked", v, 8'h40);
    wb(4'd6, 8'hFE); wb(4'd7, 8'h4F);
    rd(2'd2, 4'hF, d); chk("R5 R7 wrap read", d, 32'h0403_0201);
    wb(4'd6, 8'h10); wb(4'd7, 8'h40);
    wr(2'd2, 4'b1010, 32'hBB00_AA00);
    chk("R5 sparse first", mget(2, 16'h10), 8'hAA);
    chk("R5 sparse second", mget(2, 16'h11), 8'hBB);
    rb(4'd6, v); chk("R5 ptr after sparse", v, 8'h12);
  endtask

  task automatic t_illegal;
    logic [7:0] v;
    set_bank(2'd0);
    wb(4'd2, 8'h55); chk("R12 err bank0 off2", l_err, 1'b1);
    rb(4'd2, v);     chk("R12 off2 still zero", v, 8'h00);
    wb(4'd0, 8'h34); chk("R12 no err legal write", l_err, 1'b0);
    set_bank(2'd3);
    wb(4'd10, 8'h55); chk("R12 err bank3 off10", l_err, 1'b1);
    rb(4'd10, v);     chk("R12 revision kept", v, 8'h91);
    rb(4'd11, v);     chk("R12 no err on read", l_err, 1'b0);
  endtask

  task automatic t_cmd;
    logic [7:0] v;
    set_bank(2'd2);
    wb(4'd0, 8'hC0);
    chk("R13 cmd pulse", l_cmdv, 1'b1);
    chk("R13 cmd code", l_cmd, 3'd6);
    wb(4'd12, 8'h16);
    chk("R13 ack pulse", l_ackv, 1'b1);
    chk("R13 ack bits", l_ack, 8'h16);
    chk("R13 no cmd on ack", l_cmdv, 1'b0);
    wb(4'd13, 8'h05);
    rb(4'd13, v); chk("R13 mask readback", v, 8'h05);
    chk("R13 mask port", irq_mask, 8'h05);
    rb(4'd12, v); chk("R13 status read", v, 8'h81);
  endtask

  task automatic t_softrst;
    logic [7:0] v;
    set_bank(2'd0);
    wb(4'd4, 8'h5A);
    rb(4'd4, v); chk("R10 rx lo stored", v, 8'h5A);
    wb(4'd5, 8'h80);
    chk("R10 soft reset pulse", l_srst, 1'b1);
    rb(4'd14, v); chk("R10 bank cleared", v, 8'h00);
    rb(4'd4, v);  chk("R10 rx lo cleared", v, 8'h00);
    chk("R10 rx ctrl port", rx_ctrl, 16'h0);
    chk("R10 tx ctrl port", tx_ctrl, 16'h0);
    set_bank(2'd1);
    rb(4'd0, v); chk("R10 cfg restored", v, 8'hB1);
    set_bank(2'd2);
    rb(4'd13, v); chk("R10 mask cleared", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_bank;
    t_decode;
    t_ctrl_mask;
    t_narrow;
    t_fixed_ptr;
    t_autoinc;
    t_illegal;
    t_cmd;
    t_softrst;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule